// File: doc/BRIEF.md
# Escaped Byte-to-Symbol Link Decoder

This block sits on the receive side of an 8-bit serial link and rebuilds a 9-bit symbol stream from it. Bit 8 of a symbol separates control symbols (commas) from ordinary data bytes. Ordinary bytes pass straight through. Control information crosses the 8-bit channel as a pair of bytes: a reserved escape byte, then a code byte that protects itself. The code byte holds a fixed two-bit prefix, a 3-bit code, and the bitwise inverse of that code.

The decoder checks each code byte. A valid code becomes one of three results: a comma symbol for the four framing and status codes, a literal data byte for the codes that stand for reserved byte values, or nothing at all for the fill code. A code byte that fails the check produces a one-cycle error pulse and no symbol. The byte side uses an enable/busy handshake. The symbol side uses a valid/hold handshake. A single output register gives one symbol per cycle when the consumer is not holding.

Top module: `esc_link_decoder`

## Requirements
- R1: When no escape is open, an accepted byte that is not the escape byte (default 8'h43) appears in the cycle after acceptance as symbol {1'b0, byte} with the valid output high.
- R2: An accepted escape byte produces no symbol. The next accepted byte is always read as a code byte, whatever its value.
- R3: A valid code byte with code 0, 1, 2 or 3 (start, end, negative acknowledge, attention) produces the comma symbol {1'b1, 5'b00000, code}.
- R4: A valid code byte with code 4, 5 or 7 produces a data symbol. Code 4 gives byte 8'h11, code 5 gives byte 8'h13, and code 7 gives the escape byte.
- R5: A valid code byte with code 6 (fill) produces no symbol.
- R6: A code byte is valid only when bits 7:6 equal the prefix 2'b10 and bits 5:3 equal the inverse of bits 2:0. An invalid code byte raises the error output for exactly the one cycle after acceptance, produces no symbol, and closes the escape.
- R7: A byte is accepted only in a cycle where enable is high and busy is low. Busy is high exactly when a symbol is valid and hold is high.
- R8: While valid and hold are both high, the symbol and valid stay unchanged, and no byte is lost or duplicated.
- R9: A synchronous active-high reset clears valid, the error output and any open escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inByte | input | 8 | Incoming link byte |
| inEna | input | 1 | Byte present on inByte |
| inBusy | output | 1 | Decoder cannot take a byte this cycle |
| outSym | output | 9 | Decoded symbol; bit 8 marks a comma |
| outVal | output | 1 | outSym holds a symbol |
| outHold | input | 1 | Consumer refuses the symbol this cycle |
| errPulse | output | 1 | One-cycle pulse for a malformed code byte |

## Verification
Two situations are hard to reach from the ports. The first is a consumer that holds a pending symbol while the next byte is already waiting, which tests whether that byte is lost or taken twice. The bench stalls the consumer and keeps a second byte on the input for several cycles. It then releases hold and checks that the stalled symbol is replaced by the waiting byte exactly once. The second is a reset that arrives while an escape is open. The bench sends an escape byte, resets, and then sends a byte that would be invalid as a code byte. It checks that this byte comes out as plain data with no error pulse. All 256 values are swept both as plain bytes and as code bytes, with the expected symbols computed from the field layout.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;

  typedef enum logic {
    ST_DATA = 1'b0,
    ST_ESCD = 1'b1
  } decState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldData;   // load plain byte
    logic ldComma;  // load comma from code
    logic ldLit;    // load literal byte for code
    logic errSet;   // malformed code byte seen
  } decStrobe_t;

  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_SOP  = 3'd0;
  localparam logic [CODE_W-1:0] CODE_EOP  = 3'd1;
  localparam logic [CODE_W-1:0] CODE_NAK  = 3'd2;
  localparam logic [CODE_W-1:0] CODE_ATTN = 3'd3;
  localparam logic [CODE_W-1:0] CODE_XON  = 3'd4;
  localparam logic [CODE_W-1:0] CODE_XOFF = 3'd5;
  localparam logic [CODE_W-1:0] CODE_FILL = 3'd6;
  localparam logic [CODE_W-1:0] CODE_ESC  = 3'd7;

endpackage

// File: rtl/esc_dec_dpath.sv
module esc_dec_dpath
  import esc_dec_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          PFX_W    = 2,
  parameter logic [7:0]  ESC_BYTE = 8'h43,
  parameter logic [1:0]  PREFIX   = 2'b10,
  parameter logic [7:0]  XON_BYTE = 8'h11,
  parameter logic [7:0]  XOFF_BYTE = 8'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              outHold,
  input  decStrobe_t        strobe,
  output logic              isEsc,
  output logic              fmtOk,
  output logic [CODE_W-1:0] code,
  output logic [BYTE_W:0]   outSym,
  output logic              outVal,
  output logic              errPulse
);

  localparam int PAD_W = BYTE_W - CODE_W;

  logic [PFX_W-1:0]  pfxField;
  logic [CODE_W-1:0] invField;
  logic [BYTE_W-1:0] litByte;
  logic              anyLoad;

  assign pfxField = inByte[BYTE_W-1 -: PFX_W];
  assign invField = inByte[2*CODE_W-1 -: CODE_W];
  assign code     = inByte[CODE_W-1:0];
  assign isEsc    = (inByte == ESC_BYTE);
  assign fmtOk    = (pfxField == PREFIX) && (invField == ~code);
  assign anyLoad  = strobe.ldData | strobe.ldComma | strobe.ldLit;

  always_comb begin
    case (code)
      CODE_XON:  litByte = XON_BYTE;
      CODE_XOFF: litByte = XOFF_BYTE;
      default:   litByte = ESC_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outVal   <= 1'b0;
      outSym   <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= strobe.errSet;
      if (anyLoad) begin
        outVal <= 1'b1;
        if (strobe.ldData)
          outSym <= {1'b0, inByte};
        else if (strobe.ldComma)
          outSym <= {1'b1, {PAD_W{1'b0}}, code};
        else
          outSym <= {1'b0, litByte};
      end else if (!outHold) begin
        outVal <= 1'b0;
      end
    end
  end

  // R8: a held symbol stays put
  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (outVal && outHold) |=> (outVal && $stable(outSym)));

  // R3: comma symbols carry zero padding above the code
  a_r3_comma_shape: assert property (@(posedge clk) disable iff (rst)
    (outVal && outSym[BYTE_W]) |-> (outSym[BYTE_W-1:CODE_W] == '0));

  // R6: error lasts a single cycle
  a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
    errPulse |=> !errPulse);

endmodule

// File: rtl/esc_dec_ctrl.sv
module esc_dec_ctrl
  import esc_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inEna,
  input  logic              outVal,
  input  logic              outHold,
  input  logic              isEsc,
  input  logic              fmtOk,
  input  logic [CODE_W-1:0] code,
  output logic              inBusy,
  output decStrobe_t        strobe
);

  decState_e state, stateNxt;
  logic      take;

  assign inBusy = outVal && outHold;
  assign take   = inEna && !inBusy;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    if (take) begin
      if (state == ST_DATA) begin
        if (isEsc) stateNxt = ST_ESCD;
        else       strobe.ldData = 1'b1;
      end else begin
        stateNxt = ST_DATA;
        if (!fmtOk) begin
          strobe.errSet = 1'b1;
        end else begin
          case (code)
            CODE_SOP, CODE_EOP, CODE_NAK, CODE_ATTN: strobe.ldComma = 1'b1;
            CODE_XON, CODE_XOFF, CODE_ESC:           strobe.ldLit   = 1'b1;
            default:                                 strobe         = '0; // fill
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_DATA;
    else     state <= stateNxt;
  end

  // R2: an accepted escape byte opens an escape
  a_r2_escape_opens: assert property (@(posedge clk) disable iff (rst)
    (take && state == ST_DATA && isEsc) |=> (state == ST_ESCD));

  // R6: a malformed code byte closes the escape
  a_r6_err_closes: assert property (@(posedge clk) disable iff (rst)
    strobe.errSet |=> (state == ST_DATA));

  // R7: nothing is loaded while the consumer stalls a pending symbol
  a_r7_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    (outVal && outHold) |-> !(strobe.ldData || strobe.ldComma || strobe.ldLit || strobe.errSet));

endmodule

// File: rtl/esc_link_decoder.sv
module esc_link_decoder
  import esc_dec_pkg::*;
#(
  parameter logic [7:0] ESC_BYTE  = 8'h43,
  parameter logic [1:0] PREFIX    = 2'b10,
  parameter logic [7:0] XON_BYTE  = 8'h11,
  parameter logic [7:0] XOFF_BYTE = 8'h13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] inByte,
  input  logic       inEna,
  output logic       inBusy,
  output logic [8:0] outSym,
  output logic       outVal,
  input  logic       outHold,
  output logic       errPulse
);

  localparam int BYTE_W = 8;
  localparam int PFX_W  = 2;

  decStrobe_t        strobe;
  logic              isEsc;
  logic              fmtOk;
  logic [CODE_W-1:0] code;

  esc_dec_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inEna   (inEna),
    .outVal  (outVal),
    .outHold (outHold),
    .isEsc   (isEsc),
    .fmtOk   (fmtOk),
    .code    (code),
    .inBusy  (inBusy),
    .strobe  (strobe)
  );

  esc_dec_dpath #(
    .BYTE_W    (BYTE_W),
    .PFX_W     (PFX_W),
    .ESC_BYTE  (ESC_BYTE),
    .PREFIX    (PREFIX),
    .XON_BYTE  (XON_BYTE),
    .XOFF_BYTE (XOFF_BYTE)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .inByte   (inByte),
    .outHold  (outHold),
    .strobe   (strobe),
    .isEsc    (isEsc),
    .fmtOk    (fmtOk),
    .code     (code),
    .outSym   (outSym),
    .outVal   (outVal),
    .errPulse (errPulse)
  );

endmodule

// File: tb/tb_esc_link_decoder.sv
`timescale 1ns/1ps
module tb_esc_link_decoder;

  localparam logic [7:0] ESC = 8'h43;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] inByte;
  logic       inEna;
  logic       inBusy;
  logic [8:0] outSym;
  logic       outVal;
  logic       outHold;
  logic       errPulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  esc_link_decoder dut (
    .clk(clk), .rst(rst), .inByte(inByte), .inEna(inEna), .inBusy(inBusy),
    .outSym(outSym), .outVal(outVal), .outHold(outHold), .errPulse(errPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a byte at the falling edge, let one rising edge take it,
  // then sample at the following falling edge.
  task automatic send(input logic [7:0] b);
    inByte = b;
    inEna  = 1'b1;
    @(negedge clk);
    inEna  = 1'b0;
  endtask

  // Expected outcome for a code byte: kind 0 none, 1 symbol, 2 error
  function automatic int expKind(input logic [7:0] b);
    if (b[7:6] != 2'b10 || b[5:3] != ~b[2:0]) return 2;
    if (b[2:0] == 3'd6) return 0;
    return 1;
  endfunction

  function automatic logic [8:0] expSym(input logic [7:0] b);
    case (b[2:0])
      3'd4: return {1'b0, 8'h11};
      3'd5: return {1'b0, 8'h13};
      3'd7: return {1'b0, ESC};
      default: return {1'b1, 5'b0, b[2:0]};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; inEna = 1'b0; inByte = 8'h00; outHold = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 val", 16'(outVal), 16'd0);
    check("R9 err", 16'(errPulse), 16'd0);
    check("R7 busy idle", 16'(inBusy), 16'd0);

    // R1: every plain byte passes through
    for (int i = 0; i < 256; i++) begin
      if (i[7:0] != ESC) begin
        send(i[7:0]);
        check("R1 val", 16'(outVal), 16'd1);
        check("R1 sym", 16'(outSym), 16'({1'b0, i[7:0]}));
      end
    end

    // R2..R6: every value as a code byte after an escape
    for (int i = 0; i < 256; i++) begin
      send(ESC);
      check("R2 esc silent", 16'(outVal), 16'd0);
      send(i[7:0]);
      case (expKind(i[7:0]))
        0: begin
          check("R5 fill val", 16'(outVal), 16'd0);
          check("R5 fill err", 16'(errPulse), 16'd0);
        end
        1: begin
          check("R3/R4 val", 16'(outVal), 16'd1);
          check("R3/R4 sym", 16'(outSym), 16'(expSym(i[7:0])));
          check("R3/R4 err", 16'(errPulse), 16'd0);
        end
        default: begin
          check("R6 err", 16'(errPulse), 16'd1);
          check("R6 val", 16'(outVal), 16'd0);
          @(negedge clk);
          check("R6 err one cycle", 16'(errPulse), 16'd0);
        end
      endcase
      // escape closed: next byte is plain data
      send(8'h05);
      check("R6 escape closed", 16'(outSym), 16'h005);
    end

    // R2: escape byte value itself after escape -> code byte, malformed
    send(ESC);
    send(ESC);
    check("R2 second esc is code", 16'(errPulse), 16'd1);

    // R7: enable low takes nothing
    @(negedge clk);
    inByte = 8'h22;
    @(negedge clk);
    check("R7 enable low", 16'(outVal), 16'd0);

    // R8: stall with a waiting byte
    outHold = 1'b1;
    send(8'hA1);
    check("R8 first", 16'(outSym), 16'h0A1);
    check("R7 busy", 16'(inBusy), 16'd1);
    inByte = 8'hB2; inEna = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held sym", 16'(outSym), 16'h0A1);
      check("R8 held val", 16'(outVal), 16'd1);
    end
    outHold = 1'b0;
    @(negedge clk);
    inEna = 1'b0;
    check("R8 next sym", 16'(outSym), 16'h0B2);
    check("R8 next val", 16'(outVal), 16'd1);
    @(negedge clk);
    check("R8 no duplicate", 16'(outVal), 16'd0);

    // R9: reset in the middle of an escape
    send(ESC);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(8'h05);
    check("R9 escape cleared sym", 16'(outSym), 16'h005);
    check("R9 escape cleared err", 16'(errPulse), 16'd0);

    // R9: reset drops a held symbol
    outHold = 1'b1;
    send(8'h77);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 held cleared", 16'(outVal), 16'd0);
    outHold = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule